// File: doc/BRIEF.md
# Quasi-Resonant Valley Turn-On Controller

This block times the on and off intervals of the power switch in a quasi-resonant flyback stage. All timing comes from counters on the system clock. After every turn-off it holds a fixed blanking interval. It then waits for the zero-current detector to report that the winding voltage is high (arming). Once armed, it turns the switch on at a falling crossing of the trigger comparator, which marks a resonant valley. A programmed delay after the crossing places the turn-on at the valley bottom.

A nonzero skip count adds blanking after the first valley. Later valleys inside that interval are passed over, which lowers the switching frequency. After the skip interval a bounded wait window follows, and the switch is forced on if no further valley appears. An internal starter turns the switch on when no valley has been detected within a programmable off time.

During the on interval, leading-edge blanking masks the peak-current and overcurrent comparators. After that interval, the peak comparator ends the pulse. The overcurrent comparator also ends the pulse and raises a one-cycle event flag. A low enable holds the switch off and clears all timing.

Top module: `qr_valley_ctrl`

## Requirements
- R1: After reset, and in the clock edge after `en_i` is sampled low, `gate_o` and `oc_evt_o` are 0. While disabled, the comparators have no effect. The first turn-on after `en_i` is sampled high again happens no earlier than START_CYC edges later, counted from that edge.
- R2: For MIN_BLANK edges after the edge that turns the gate off, arm samples are ignored. Falling trigger crossings that are sampled before the block is armed never turn the gate on.
- R3: The block arms at the first edge after the blanking interval at which `zc_arm_i` is sampled 1. Once armed, it stays armed even if `zc_arm_i` falls.
- R4: With the skip count at zero, a falling crossing is detected at an edge where `zc_trig_i` is sampled 0 after being sampled 1 at the previous edge. If the block is armed at that edge, `gate_o` rises VALLEY_DLY+1 edges later.
- R5: With skip count S > 0, the first valley starts S cycles in which crossings are ignored. A crossing detected in the wait window after that interval turns the gate on VALLEY_DLY+1 edges later.
- R6: If no crossing is detected within WAIT_CYC edges after the skip interval ends, the turn-on sequence starts at the last of those edges, and `gate_o` rises VALLEY_DLY+1 edges after it.
- R7: If no valley is detected, the gate rises exactly START_CYC edges after the turn-off edge. Once a first valley is detected, the starter no longer acts in that off interval.
- R8: Comparator samples at the first LEB_CYC edges after the turn-on edge are ignored.
- R9: When `pk_cmp_i` is sampled 1 after leading-edge blanking, `gate_o` falls at that edge and `oc_evt_o` stays 0.
- R10: When `oc_cmp_i` is sampled 1 after leading-edge blanking, `gate_o` falls at that edge and `oc_evt_o` is 1 for exactly one cycle. This takes priority over the peak comparator.
- R11: The skip count is captured at the first valley. Changing `skip_cyc_i` later in the same off interval has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low forces the gate off and clears timing |
| zc_arm_i | input | 1 | Zero-current arm comparator (winding voltage above arm level) |
| zc_trig_i | input | 1 | Zero-current trigger comparator (1 above trigger level) |
| pk_cmp_i | input | 1 | Peak-current comparator |
| oc_cmp_i | input | 1 | Overcurrent comparator |
| skip_cyc_i | input | SKIP_W | Extra valley-skip blanking in clock cycles; 0 disables |
| gate_o | output | 1 | Registered gate drive |
| oc_evt_o | output | 1 | One-cycle overcurrent turn-off event |

## Verification
The bench builds the block with MIN_BLANK=4, WAIT_CYC=6, LEB_CYC=3, VALLEY_DLY=2, START_CYC=40 and a 4-bit skip count. With these values, every skip count from 1 to 15 can be swept, each with a crossing on both sides of the end of the skip interval. The valley position is stepped across the whole armed window, and the peak pulse is stepped across every leading-edge blanking cycle. The starter time stays short, so the starter path and a skip-plus-wait path that outlasts it both finish in a few dozen cycles.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_SEEK,
    ST_ARMED,
    ST_SKIP,
    ST_HUNT,
    ST_DELAY,
    ST_ON
  } qrv_state_t;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qrv_fall_det.sv
module qrv_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= 1'b0;
    else if (clr_i) prev_q <= 1'b0;
    else            prev_q <= sig_i;
  end

  // high sample followed by a low sample
  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/qrv_starter.sv
module qrv_starter #(
  parameter int unsigned START_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic fire_o
);
  localparam int unsigned TW = $clog2(START_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(START_CYC - 1);
  localparam logic [TW-1:0] ONE  = TW'(1);

  logic [TW-1:0] toff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         toff_q <= '0;
    else if (restart_i)                 toff_q <= '0;
    else if (run_i && toff_q != LAST)   toff_q <= toff_q + ONE;
  end

  assign fire_o = run_i && (toff_q == LAST);
endmodule

// File: rtl/qrv_sequencer.sv
module qrv_sequencer
  import qrv_pkg::*;
#(
  parameter int unsigned MIN_BLANK  = 175,
  parameter int unsigned WAIT_CYC   = 650,
  parameter int unsigned LEB_CYC    = 34,
  parameter int unsigned VALLEY_DLY = 8,
  parameter int unsigned SKIP_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              arm_i,
  input  logic              fall_i,
  input  logic              peak_i,
  input  logic              ocp_i,
  input  logic              fire_i,
  input  logic [SKIP_W-1:0] skip_i,
  output qrv_state_t        state_o,
  output logic              ocp_evt_o
);
  localparam int unsigned CNT_W =
    imax(imax(imax($clog2(MIN_BLANK + 1), $clog2(WAIT_CYC + 1)),
              imax($clog2(LEB_CYC + 1), $clog2(VALLEY_DLY + 1))), SKIP_W);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0] BLANK_LAST = CNT_W'(MIN_BLANK - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] DLY_LAST   = CNT_W'(VALLEY_DLY);
  localparam logic [CNT_W-1:0] LEB_LAST   = CNT_W'(LEB_CYC);

  qrv_state_t        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SKIP_W-1:0] skip_q, skip_n;
  logic              evt_q, evt_n;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    skip_n = skip_q;
    evt_n  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        st_n  = ST_BLANK;
        cnt_n = '0;
      end
      ST_BLANK: begin
        if (fire_i) begin
          st_n  = ST_ON;
          cnt_n = '0;
        end else if (cnt_q == BLANK_LAST) begin
          st_n  = ST_SEEK;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end
      ST_SEEK: begin
        if (fire_i) begin
          st_n  = ST_ON;
          cnt_n = '0;
        end else if (arm_i) begin
          st_n = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (fall_i) begin
          skip_n = skip_i;
          cnt_n  = '0;
          st_n   = (skip_i == '0) ? ST_DELAY : ST_SKIP;
        end else if (fire_i) begin
          st_n  = ST_ON;
          cnt_n = '0;
        end
      end
      ST_SKIP: begin
        if (cnt_q + ONE == CNT_W'(skip_q)) begin
          st_n  = ST_HUNT;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end
      ST_HUNT: begin
        if (fall_i || cnt_q == WAIT_LAST) begin
          st_n  = ST_DELAY;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end
      ST_DELAY: begin
        if (cnt_q == DLY_LAST) begin
          st_n  = ST_ON;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + ONE;
        end
      end
      ST_ON: begin
        if (cnt_q != LEB_LAST) begin
          cnt_n = cnt_q + ONE;
        end else if (ocp_i) begin
          st_n  = ST_BLANK;
          cnt_n = '0;
          evt_n = 1'b1;
        end else if (peak_i) begin
          st_n  = ST_BLANK;
          cnt_n = '0;
        end
      end
    endcase
    if (!en_i) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      skip_n = '0;
      evt_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      skip_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      skip_q <= skip_n;
      evt_q  <= evt_n;
    end
  end

  assign state_o   = st_q;
  assign ocp_evt_o = evt_q;
endmodule

// File: rtl/qr_valley_ctrl.sv
module qr_valley_ctrl
  import qrv_pkg::*;
#(
  parameter int unsigned MIN_BLANK  = 175,
  parameter int unsigned WAIT_CYC   = 650,
  parameter int unsigned LEB_CYC    = 34,
  parameter int unsigned VALLEY_DLY = 8,
  parameter int unsigned START_CYC  = 15000,
  parameter int unsigned SKIP_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              zc_arm_i,
  input  logic              zc_trig_i,
  input  logic              pk_cmp_i,
  input  logic              oc_cmp_i,
  input  logic [SKIP_W-1:0] skip_cyc_i,
  output logic              gate_o,
  output logic              oc_evt_o
);
  qrv_state_t state;
  logic       fall;
  logic       fire;
  logic       pre_valley;

  assign pre_valley = (state == ST_BLANK) || (state == ST_SEEK) || (state == ST_ARMED);

  qrv_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (!en_i),
    .sig_i  (zc_trig_i),
    .fall_o (fall)
  );

  qrv_starter #(
    .START_CYC (START_CYC)
  ) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (!pre_valley),
    .run_i     (pre_valley),
    .fire_o    (fire)
  );

  qrv_sequencer #(
    .MIN_BLANK  (MIN_BLANK),
    .WAIT_CYC   (WAIT_CYC),
    .LEB_CYC    (LEB_CYC),
    .VALLEY_DLY (VALLEY_DLY),
    .SKIP_W     (SKIP_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .arm_i     (zc_arm_i),
    .fall_i    (fall),
    .peak_i    (pk_cmp_i),
    .ocp_i     (oc_cmp_i),
    .fire_i    (fire),
    .skip_i    (skip_cyc_i),
    .state_o   (state),
    .ocp_evt_o (oc_evt_o)
  );

  assign gate_o = (state == ST_ON);
endmodule

// File: rtl/qrv_chk.sv
module qrv_chk #(
  parameter int unsigned MIN_BLANK = 175,
  parameter int unsigned LEB_CYC   = 34
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic gate_o,
  input logic oc_evt_o
);
  localparam int unsigned ON_W  = $clog2(LEB_CYC + 2);
  localparam int unsigned OFF_W = $clog2(MIN_BLANK + 2);

  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_cnt  <= '0;
      off_cnt <= '0;
    end else begin
      if (!gate_o)                        on_cnt <= '0;
      else if (on_cnt != ON_W'(LEB_CYC))  on_cnt <= on_cnt + ON_W'(1);
      if (gate_o)                              off_cnt <= '0;
      else if (off_cnt != OFF_W'(MIN_BLANK + 1)) off_cnt <= off_cnt + OFF_W'(1);
    end
  end

  // R1
  disabled_gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_o && !oc_evt_o));

  // R2
  min_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (off_cnt > OFF_W'(MIN_BLANK)));

  // R8
  leb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && gate_o && on_cnt < ON_W'(LEB_CYC)) |=> gate_o);

  // R10
  oc_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt_o |=> !oc_evt_o);

  // R10
  oc_evt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_evt_o |-> (!gate_o && $past(gate_o)));
endmodule

bind qr_valley_ctrl qrv_chk #(
  .MIN_BLANK (MIN_BLANK),
  .LEB_CYC   (LEB_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .gate_o   (gate_o),
  .oc_evt_o (oc_evt_o)
);

// File: tb/tb_qr_valley_ctrl.sv
module tb_qr_valley_ctrl;
  localparam int MB = 4, WT = 6, LEB = 3, VD = 2, ST = 40, SW = 4;
  localparam int NONE = 100000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic arm = 1'b0, trig = 1'b1, pk = 1'b0, oc = 1'b0;
  logic [SW-1:0] skip = '0;
  logic gate, evt;
  int checks = 0, errors = 0, cyc = 0;

  qr_valley_ctrl #(.MIN_BLANK(MB), .WAIT_CYC(WT), .LEB_CYC(LEB), .VALLEY_DLY(VD),
                   .START_CYC(ST), .SKIP_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .zc_arm_i(arm), .zc_trig_i(trig),
    .pk_cmp_i(pk), .oc_cmp_i(oc), .skip_cyc_i(skip), .gate_o(gate), .oc_evt_o(evt));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // t=0 is the negedge right after the turn-off (or enable) edge
  task automatic off_phase(input int a_on, input int a_off, input int f1, input int f2,
                           input int chg_t, input int chg_v, input int limit,
                           output int rise, output int evt1);
    rise = -1;
    evt1 = 0;
    for (int t = 0; t <= limit; t++) begin
      if (t == 1) evt1 = int'(evt);
      if (t > 0 && gate) begin
        rise = t;
        return;
      end
      pk   = 1'b0;
      oc   = 1'b0;
      arm  = (t >= a_on && t < a_off);
      trig = !(t == f1 || t == f2);
      if (t == chg_t) skip = SW'(chg_v);
      @(negedge clk);
    end
  endtask

  // u=0 is the negedge where the gate is first seen high
  task automatic on_phase(input int p_pulse, input int p_from, input int o_from,
                          output int fall, output int evt_at);
    fall = -1;
    evt_at = 0;
    for (int u = 0; u <= 200; u++) begin
      if (!gate) begin
        fall = u;
        evt_at = int'(evt);
        return;
      end
      arm  = 1'b0;
      trig = 1'b1;
      pk   = (u == p_pulse) || (u >= p_from);
      oc   = (u >= o_from);
      @(negedge clk);
    end
  endtask

  // plain valley off interval ending with gate high
  task automatic quick_on();
    int r, e;
    off_phase(0, NONE, MB + 1, -1, -1, 0, 200, r, e);
    check("R4 quick valley", r, MB + 3 + VD);
  endtask

  task automatic std_off();
    int f, e;
    on_phase(NONE, LEB, NONE, f, e);
    check("R9 peak turn-off time", f, LEB + 1);
  endtask

  initial begin
    int r, e, f, j;
    repeat (3) @(negedge clk);
    check("R1 reset gate", int'(gate), 0);
    check("R1 reset event", int'(evt), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      arm = k[0]; trig = k[1]; pk = 1'b1; oc = k[0];
      @(negedge clk);
      check("R1 disabled gate", int'(gate), 0);
      check("R1 disabled event", int'(evt), 0);
    end
    pk = 1'b0; oc = 1'b0; trig = 1'b1; arm = 1'b0;
    en = 1'b1;
    @(negedge clk);
    off_phase(NONE, NONE, -1, -1, -1, 0, 200, r, e);
    check("R1 R7 first start after enable", r, ST);

    on_phase(NONE, LEB, NONE, f, e);
    check("R9 peak turn-off time", f, LEB + 1);
    check("R9 no event on peak", e, 0);

    // R4: valley position sweep over the armed window
    for (int jj = MB + 1; jj <= MB + 12; jj++) begin
      off_phase(0, NONE, jj, -1, -1, 0, 200, r, e);
      check("R4 valley delay", r, jj + 2 + VD);
      std_off();
    end

    // R2: crossings before arming are ignored
    for (int jj = 0; jj <= MB; jj++) begin
      off_phase(0, NONE, jj, -1, -1, 0, 200, r, e);
      check("R2 early crossing ignored", r, ST);
      std_off();
      off_phase(0, NONE, jj, MB + 3, -1, 0, 200, r, e);
      check("R2 later crossing accepted", r, MB + 5 + VD);
      std_off();
    end

    // R3: arming
    off_phase(0, MB, MB + 3, -1, -1, 0, 200, r, e);
    check("R3 arm only in blanking", r, ST);
    std_off();
    off_phase(10, NONE, 10, 12, -1, 0, 200, r, e);
    check("R3 late arm", r, 12 + 2 + VD);
    std_off();
    off_phase(MB, MB + 1, 8, -1, -1, 0, 200, r, e);
    check("R3 arm held after pulse", r, 8 + 2 + VD);
    std_off();

    // R8: leading-edge blanking sweep
    for (int p = 0; p <= LEB + 2; p++) begin
      quick_on();
      on_phase(p, LEB + 6, NONE, f, e);
      check("R8 blanking of peak pulse", f, (p >= LEB) ? p + 1 : LEB + 7);
    end

    // R10: overcurrent
    quick_on();
    on_phase(NONE, 0, 0, f, e);
    check("R10 ocp turn-off time", f, LEB + 1);
    check("R10 event at turn-off", e, 1);
    off_phase(0, NONE, MB + 1, -1, -1, 0, 200, r, e);
    check("R10 event single cycle", e, 0);
    on_phase(NONE, NONE, 5, f, e);
    check("R10 late ocp", f, 6);
    check("R10 late ocp event", e, 1);
    quick_on();
    on_phase(NONE, NONE, 1, f, e);
    check("R8 R10 ocp during blanking", f, LEB + 1);

    // R5 and R6: skip sweep
    j = MB + 1;
    for (int s = 1; s <= 15; s++) begin
      skip = SW'(s);
      off_phase(0, NONE, j, j + s + 1, -1, 0, 200, r, e);
      check("R5 crossing after skip", r, j + s + 1 + 2 + VD);
      std_off();
      off_phase(0, NONE, j, j + s, -1, 0, 200, r, e);
      check("R6 crossing in skip ignored", r, j + s + WT + VD + 2);
      std_off();
    end

    // R6 and R7: long skip with no crossing outlasts the starter
    skip = SW'(15);
    off_phase(0, NONE, 30, -1, -1, 0, 200, r, e);
    check("R6 R7 no starter after valley", r, 30 + 15 + WT + VD + 2);
    std_off();
    off_phase(0, NONE, 30 + 15 + 3, -1, -1, 0, 200, r, e);
    check("R7 starter wins late valley", r, ST);
    std_off();

    // R11: skip captured at the valley
    skip = SW'(3);
    off_phase(0, NONE, j, -1, j + 1, 15, 200, r, e);
    check("R11 skip latched", r, j + 3 + WT + VD + 2);
    std_off();
    skip = SW'(3);
    off_phase(0, NONE, j, -1, j, 0, 200, r, e);
    check("R11 skip read at valley", r, j + 2 + VD);
    std_off();

    // R1: disable while on, and while the starter is running
    off_phase(0, NONE, MB + 1, -1, -1, 0, 200, r, e);
    en = 1'b0; pk = 1'b0;
    @(negedge clk);
    check("R1 gate off after disable", int'(gate), 0);
    for (int k = 0; k < 8; k++) begin
      arm = 1'b1; trig = k[0]; oc = 1'b1;
      @(negedge clk);
      check("R1 comparators ignored when disabled", int'(gate), 0);
    end
    oc = 1'b0; trig = 1'b1; arm = 1'b0;
    en = 1'b1;
    @(negedge clk);
    off_phase(NONE, NONE, -1, -1, -1, 0, 20, r, e);
    check("R1 no turn-on in first part", r, -1);
    en = 1'b0;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    off_phase(NONE, NONE, -1, -1, -1, 0, 200, r, e);
    check("R1 starter restarted by enable", r, ST);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule